// File: doc/BRIEF.md
# Pixel Bit-Depth Reducer with Random Dither

This block takes a stream of three-component pixels, each component 12 bits wide, and lowers the number of significant bits per component to 6, 8 or 10. Two reduction methods are available. One truncates the low bits, optionally rounding by first adding half an output LSB. The other is spatial random dithering: it adds pseudo-random noise to the low bits and then truncates. The noise comes from 28-bit linear feedback shift registers. Either one register feeds all three channels, or each channel has its own feedback tap.

The output keeps the 12-bit MSB-aligned format. The retained bits sit at the top and the discarded positions read zero. All controls are static fields that the surrounding logic holds steady while pixels flow. The pixel valid and start-of-frame markers travel through a fixed two-stage pipeline together with the data. The random registers can be reseeded at every frame start, and an optional high-pass option shapes the noise.

Top module: `bitdepth_reducer`

## Requirements
- R1: Each output appears exactly 2 clock cycles after its input is sampled. `out_valid` and `out_sof` are the input markers delayed by 2 cycles, and `out_sof` is never high without `out_valid`.
- R2: When `dith_en` and `trunc_en` are both 0, every component passes through unchanged.
- R3: With truncation active and `trunc_mode`=0, depth code 0 keeps the top 6 bits, code 1 keeps 8 bits, code 2 keeps 10 bits and code 3 keeps all 12 bits. The dropped low bits are output as zero.
- R4: With `trunc_mode`=1, half an output LSB (1 << (dropped-1)) is added before the low bits are dropped. A sum above 12'hFFF saturates to the largest retained code (all kept bits 1).
- R5: When `in_is422`=1, truncation ignores `trunc_mode` and always behaves as mode 0. Depth codes 0 and 3 then disable truncation, so the data passes unchanged.
- R6: When `dith_en`=1, dithering takes priority over truncation. The bits kept are selected by `dith_depth` with the R3 code meanings. The noise, masked to the dropped bits, is added to the component, the sum saturates as in R4, and the result is then truncated.
- R7: Each random register steps as next = {s[26:0], s[27] ^ s[t-1]} for the polynomial x^28 + x^t + 1. The noise of a channel is the low 12 bits of its register state. When `chan_rand`=0, all three channels use the t=3 register.
- R8: When `chan_rand`=1, the R channel uses t=3, the G channel uses t=9 and the B channel uses t=13.
- R9: The seed is a 28-bit repetition of a nibble chosen by `dith_mode`: 0 gives 4'hA, 1 gives 4'h5, 2 gives 4'hC and 3 gives 4'h3. Reset loads the seed. Each valid pixel uses the current state, and the register then steps once.
- R10: When `frame_rand`=1, a valid pixel with `in_sof`=1 uses the seed as the state. The register then steps from the seed. When `frame_rand`=0, `in_sof` does not affect the noise.
- R11: When `hp_rand`=1, the noise applied is the current sample minus the previous valid pixel's sample for that channel, modulo 4096. The previous sample is zero after reset and is updated on every valid pixel whether or not `hp_rand` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input pixel valid |
| in_sof | input | 1 | Input start of frame |
| in_r | input | 12 | Red / Cr component |
| in_g | input | 12 | Green / Y component |
| in_b | input | 12 | Blue / Cb component |
| in_is422 | input | 1 | Pixel is YCbCr 4:2:2 |
| trunc_en | input | 1 | Truncation enable |
| trunc_depth | input | 2 | Truncation depth code |
| trunc_mode | input | 1 | 0 truncate, 1 round |
| dith_en | input | 1 | Spatial dither enable |
| dith_depth | input | 2 | Dither depth code |
| dith_mode | input | 2 | Seed pattern select |
| frame_rand | input | 1 | Reseed at each frame start |
| chan_rand | input | 1 | Per-channel polynomial select |
| hp_rand | input | 1 | High-pass noise enable |
| out_valid | output | 1 | Output valid |
| out_sof | output | 1 | Output start of frame |
| out_r | output | 12 | Reduced red component |
| out_g | output | 12 | Reduced green component |
| out_b | output | 12 | Reduced blue component |

## Verification
Truncation is tried on values with non-zero low bits at every depth code. The checks show which code keeps how many bits, and rounding is told apart from plain truncation by values just below and at a rounding step. Values near full scale show that saturation replaces wrap-around, and 4:2:2 inputs show that mode and depth are restricted. Dither runs compare short pixel sequences against an independent register model. They separate the shared and per-channel taps, the seed patterns, reseeding at a frame start against free running, and high-pass against direct noise.

// File: rtl/bdr_pkg.sv
// Shared constants and helpers for the bit-depth reducer.
// Assumes components are MSB-aligned and depth codes are 2 bits wide.
package bdr_pkg;
    localparam int PIX_W  = 12;
    localparam int LFSR_W = 28;
    localparam int NCH    = 3;

    // Number of low bits discarded for a depth code.
    function automatic int drop_of(input logic [1:0] code, input int pix_w);
        case (code)
            2'd0:    return pix_w - 6;
            2'd1:    return pix_w - 8;
            2'd2:    return pix_w - 10;
            default: return 0;
        endcase
    endfunction

    // Seed built by repeating a nibble chosen by the seed-pattern field.
    function automatic logic [LFSR_W-1:0] seed_of(input logic [1:0] sel);
        logic [3:0]        pat;
        logic [LFSR_W-1:0] s;
        case (sel)
            2'd0:    pat = 4'hA;
            2'd1:    pat = 4'h5;
            2'd2:    pat = 4'hC;
            default: pat = 4'h3;
        endcase
        for (int i = 0; i < LFSR_W; i++) s[i] = pat[i % 4];
        return s;
    endfunction

    // Feedback tap of the polynomial used by each channel.
    function automatic int tap_of(input int ch);
        case (ch)
            0:       return 3;
            1:       return 9;
            default: return 13;
        endcase
    endfunction
endpackage

// File: rtl/bdr_lfsr.sv
// Fibonacci shift register for x^W + x^TAP + 1.
// Reset loads the seed. A reload request makes the seed the state that is
// used this cycle. The register steps once per advance from the used state.
module bdr_lfsr #(
    parameter int W   = 28,
    parameter int TAP = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         adv,
    input  logic         reload,
    input  logic [W-1:0] seed,
    output logic [W-1:0] cur
);
    logic [W-1:0] state;

    // Select the state seen by this pixel.
    always_comb cur = reload ? seed : state;

    // Load the seed at reset, otherwise step on each advance.
    always_ff @(posedge clk) begin
        if (!rst_n)   state <= seed;
        else if (adv) state <= {cur[W-2:0], cur[W-1] ^ cur[TAP-1]};
    end
endmodule

// File: rtl/bdr_noise.sv
// Produces one noise word per channel from three shift registers.
// Assumes the control fields are static while pixels flow.
module bdr_noise
    import bdr_pkg::*;
#(
    parameter int PW  = PIX_W,
    parameter int LW  = LFSR_W,
    parameter int NC  = NCH
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  adv,
    input  logic                  sof,
    input  logic [1:0]            seed_sel,
    input  logic                  frame_rand,
    input  logic                  chan_rand,
    input  logic                  hp_rand,
    output logic [NC-1:0][PW-1:0] noise
);
    logic [LW-1:0]          seed;
    logic                   reload;
    logic [NC-1:0][LW-1:0]  cur;
    logic [NC-1:0][PW-1:0]  raw;
    logic [NC-1:0][PW-1:0]  prev;

    // Seed and frame-start reload decision.
    always_comb begin
        seed   = seed_of(seed_sel);
        reload = adv && sof && frame_rand;
    end

    for (genvar c = 0; c < NC; c++) begin : g_ch
        localparam int TAPC = tap_of(c);

        bdr_lfsr #(.W(LW), .TAP(TAPC)) u_lfsr (
            .clk    (clk),
            .rst_n  (rst_n),
            .adv    (adv),
            .reload (reload),
            .seed   (seed),
            .cur    (cur[c])
        );

        // Pick the shared or per-channel sample and apply high-pass.
        always_comb begin
            raw[c]   = chan_rand ? cur[c][PW-1:0] : cur[0][PW-1:0];
            noise[c] = hp_rand ? (raw[c] - prev[c]) : raw[c];
        end

        // Hold the previous sample for the high-pass difference.
        always_ff @(posedge clk) begin
            if (!rst_n)   prev[c] <= '0;
            else if (adv) prev[c] <= raw[c];
        end
    end
endmodule

// File: rtl/bdr_reduce.sv
// Adds an offset to one component, saturates, and clears the dropped bits.
// Assumes drop never exceeds PW.
module bdr_reduce #(
    parameter int PW = 12,
    parameter int DW = 4
) (
    input  logic [PW-1:0] value,
    input  logic [PW-1:0] addend,
    input  logic [DW-1:0] drop,
    output logic [PW-1:0] result
);
    logic [PW:0]   sum;
    logic [PW-1:0] keep;

    // Saturating add followed by truncation of the low bits.
    always_comb begin
        sum    = {1'b0, value} + {1'b0, addend};
        keep   = {PW{1'b1}} << drop;
        result = sum[PW] ? keep : (sum[PW-1:0] & keep);
    end
endmodule

// File: rtl/bitdepth_reducer.sv
// Three-channel bit-depth reducer with truncate, round and random dither.
// Stage 1 resolves the mode and registers value, offset and drop count.
// Stage 2 registers the reduced result. Latency is two cycles.
// Assumes control inputs are static while pixels flow.
module bitdepth_reducer
    import bdr_pkg::*;
#(
    parameter int PW = PIX_W,
    parameter int LW = LFSR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic          in_sof,
    input  logic [PW-1:0] in_r,
    input  logic [PW-1:0] in_g,
    input  logic [PW-1:0] in_b,
    input  logic          in_is422,
    input  logic          trunc_en,
    input  logic [1:0]    trunc_depth,
    input  logic          trunc_mode,
    input  logic          dith_en,
    input  logic [1:0]    dith_depth,
    input  logic [1:0]    dith_mode,
    input  logic          frame_rand,
    input  logic          chan_rand,
    input  logic          hp_rand,
    output logic          out_valid,
    output logic          out_sof,
    output logic [PW-1:0] out_r,
    output logic [PW-1:0] out_g,
    output logic [PW-1:0] out_b
);
    localparam int NC = NCH;
    localparam int DW = $clog2(PW + 1);

    logic [NC-1:0][PW-1:0] noise;
    logic [NC-1:0][PW-1:0] pix_in;
    logic [NC-1:0][PW-1:0] add_d;
    logic [DW-1:0]         drop_d;
    logic [PW-1:0]         mask_d;
    logic [PW-1:0]         half_d;
    logic                  trunc_go;
    logic                  round_go;

    logic [NC-1:0][PW-1:0] s1_val;
    logic [NC-1:0][PW-1:0] s1_add;
    logic [DW-1:0]         s1_drop;
    logic                  s1_valid;
    logic                  s1_sof;
    logic [NC-1:0][PW-1:0] s2_res;

    bdr_noise #(.PW(PW), .LW(LW), .NC(NC)) u_noise (
        .clk        (clk),
        .rst_n      (rst_n),
        .adv        (in_valid),
        .sof        (in_sof),
        .seed_sel   (dith_mode),
        .frame_rand (frame_rand),
        .chan_rand  (chan_rand),
        .hp_rand    (hp_rand),
        .noise      (noise)
    );

    // Resolve method, drop count and per-channel offset.
    always_comb begin
        pix_in   = {in_b, in_g, in_r};
        trunc_go = trunc_en && (!in_is422 || trunc_depth == 2'd1 || trunc_depth == 2'd2);
        round_go = trunc_mode && !in_is422;
        if (dith_en)       drop_d = DW'(drop_of(dith_depth, PW));
        else if (trunc_go) drop_d = DW'(drop_of(trunc_depth, PW));
        else               drop_d = '0;
        mask_d = ~({PW{1'b1}} << drop_d);
        half_d = (drop_d == '0) ? '0 : ({{(PW-1){1'b0}}, 1'b1} << (drop_d - DW'(1)));
        for (int c = 0; c < NC; c++) begin
            if (dith_en)                    add_d[c] = noise[c] & mask_d;
            else if (trunc_go && round_go)  add_d[c] = half_d;
            else                            add_d[c] = '0;
        end
    end

    // Stage 1 register: value, offset, drop count and markers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_val   <= '0;
            s1_add   <= '0;
            s1_drop  <= '0;
            s1_valid <= 1'b0;
            s1_sof   <= 1'b0;
        end else begin
            s1_val   <= pix_in;
            s1_add   <= add_d;
            s1_drop  <= drop_d;
            s1_valid <= in_valid;
            s1_sof   <= in_sof && in_valid;
        end
    end

    logic [NC-1:0][PW-1:0] red_q;

    for (genvar c = 0; c < NC; c++) begin : g_red
        bdr_reduce #(.PW(PW), .DW(DW)) u_red (
            .value  (s1_val[c]),
            .addend (s1_add[c]),
            .drop   (s1_drop),
            .result (red_q[c])
        );
    end

    // Stage 2 register: reduced components and markers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s2_res    <= '0;
            out_valid <= 1'b0;
            out_sof   <= 1'b0;
        end else begin
            s2_res    <= red_q;
            out_valid <= s1_valid;
            out_sof   <= s1_sof;
        end
    end

    // Split the packed result into the output ports.
    always_comb begin
        out_r = s2_res[0];
        out_g = s2_res[1];
        out_b = s2_res[2];
    end
endmodule

// File: rtl/bdr_checker.sv
// Timing and value properties of the bit-depth reducer, bound to its top.
module bdr_checker #(
    parameter int PW = 12
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic          in_sof,
    input logic [PW-1:0] in_r,
    input logic [PW-1:0] in_g,
    input logic [PW-1:0] in_b,
    input logic          in_is422,
    input logic          trunc_en,
    input logic [1:0]    trunc_depth,
    input logic          trunc_mode,
    input logic          dith_en,
    input logic [1:0]    dith_depth,
    input logic          out_valid,
    input logic          out_sof,
    input logic [PW-1:0] out_r,
    input logic [PW-1:0] out_g,
    input logic [PW-1:0] out_b
);
    logic [1:0] since_rst;

    // Count cycles since reset, saturating at two.
    always_ff @(posedge clk) begin
        if (!rst_n)                 since_rst <= 2'd0;
        else if (since_rst != 2'd2) since_rst <= since_rst + 2'd1;
    end

    logic warm;
    always_comb warm = (since_rst == 2'd2);

    p_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
        warm |-> (out_valid == $past(in_valid, 2)));

    p_sof_valid_r1: assert property (@(posedge clk) disable iff (!rst_n)
        out_sof |-> out_valid);

    p_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && out_valid && $past(!trunc_en && !dith_en, 2))
        |-> (out_r == $past(in_r, 2) && out_g == $past(in_g, 2) && out_b == $past(in_b, 2)));

    p_trunc_floor_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && out_valid && $past(trunc_en && !dith_en && !trunc_mode, 2))
        |-> (out_r <= $past(in_r, 2)));

    p_six_bit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && out_valid && $past(trunc_en && !dith_en && trunc_depth == 2'd0 && !in_is422, 2))
        |-> (out_r[5:0] == 6'd0 && out_b[5:0] == 6'd0));

    p_dither_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && out_valid && $past(dith_en && dith_depth == 2'd1, 2))
        |-> (out_g[3:0] == 4'd0));
endmodule

bind bitdepth_reducer bdr_checker #(.PW(PW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_sof      (in_sof),
    .in_r        (in_r),
    .in_g        (in_g),
    .in_b        (in_b),
    .in_is422    (in_is422),
    .trunc_en    (trunc_en),
    .trunc_depth (trunc_depth),
    .trunc_mode  (trunc_mode),
    .dith_en     (dith_en),
    .dith_depth  (dith_depth),
    .out_valid   (out_valid),
    .out_sof     (out_sof),
    .out_r       (out_r),
    .out_g       (out_g),
    .out_b       (out_b)
);

// File: tb/bitdepth_reducer_tb.sv
module bitdepth_reducer_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 13;
    // {is422, trunc_en, depth[1:0], mode, in[11:0], exp[11:0]}
    localparam logic [28:0] VEC [NV] = '{
        {1'b0, 1'b0, 2'd0, 1'b0, 12'hABC, 12'hABC},
        {1'b0, 1'b1, 2'd0, 1'b0, 12'hABC, 12'hA80},
        {1'b0, 1'b1, 2'd1, 1'b0, 12'hABC, 12'hAB0},
        {1'b0, 1'b1, 2'd2, 1'b0, 12'hABF, 12'hABC},
        {1'b0, 1'b1, 2'd3, 1'b0, 12'hABF, 12'hABF},
        {1'b0, 1'b1, 2'd0, 1'b1, 12'hABC, 12'hAC0},
        {1'b0, 1'b1, 2'd1, 1'b1, 12'hAB8, 12'hAC0},
        {1'b0, 1'b1, 2'd2, 1'b1, 12'hFFE, 12'hFFC},
        {1'b0, 1'b1, 2'd0, 1'b1, 12'hFFF, 12'hFC0},
        {1'b1, 1'b1, 2'd1, 1'b1, 12'hAB8, 12'hAB0},
        {1'b1, 1'b1, 2'd0, 1'b0, 12'hABC, 12'hABC},
        {1'b1, 1'b1, 2'd2, 1'b1, 12'hABF, 12'hABC},
        {1'b0, 1'b1, 2'd1, 1'b1, 12'h007, 12'h000}
    };

    logic clk = 1'b0;
    logic rst_n;
    logic in_valid, in_sof, in_is422, trunc_en, trunc_mode, dith_en;
    logic frame_rand, chan_rand, hp_rand;
    logic [1:0] trunc_depth, dith_depth, dith_mode;
    logic [11:0] in_r, in_g, in_b;
    logic out_valid, out_sof;
    logic [11:0] out_r, out_g, out_b;

    int total = 0;
    int bad = 0;
    logic [27:0] m [3];
    logic [11:0] mprev [3];

    always #(CLK_PERIOD/2) clk = ~clk;

    bitdepth_reducer u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
        .in_r(in_r), .in_g(in_g), .in_b(in_b), .in_is422(in_is422),
        .trunc_en(trunc_en), .trunc_depth(trunc_depth), .trunc_mode(trunc_mode),
        .dith_en(dith_en), .dith_depth(dith_depth), .dith_mode(dith_mode),
        .frame_rand(frame_rand), .chan_rand(chan_rand), .hp_rand(hp_rand),
        .out_valid(out_valid), .out_sof(out_sof),
        .out_r(out_r), .out_g(out_g), .out_b(out_b)
    );

    task automatic check(input string req, input logic [11:0] act, input logic [11:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [27:0] seed_m(input logic [1:0] sel);
        logic [3:0] p;
        logic [27:0] s;
        p = (sel == 2'd0) ? 4'hA : (sel == 2'd1) ? 4'h5 : (sel == 2'd2) ? 4'hC : 4'h3;
        for (int i = 0; i < 28; i++) s[i] = p[i % 4];
        return s;
    endfunction

    function automatic logic [27:0] step_m(input logic [27:0] s, input int t);
        return {s[26:0], s[27] ^ s[t-1]};
    endfunction

    function automatic int tap_m(input int c);
        return (c == 0) ? 3 : (c == 1) ? 9 : 13;
    endfunction

    function automatic logic [11:0] red_m(input logic [11:0] v, input logic [11:0] a, input int drop);
        logic [12:0] s;
        logic [11:0] keep;
        keep = 12'hFFF << drop;
        s = {1'b0, v} + {1'b0, a};
        return s[12] ? keep : (s[11:0] & keep);
    endfunction

    task automatic do_reset();
        rst_n = 1'b0; in_valid = 1'b0; in_sof = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int c = 0; c < 3; c++) begin m[c] = seed_m(dith_mode); mprev[c] = '0; end
    endtask

    // Present one pixel and sample the result two edges later.
    task automatic send(input logic [11:0] r, input logic [11:0] g, input logic [11:0] b, input logic sof);
        @(negedge clk);
        in_r = r; in_g = g; in_b = b; in_sof = sof; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0; in_sof = 1'b0;
        total++;
        if (out_valid !== 1'b0) begin bad++; $display("FAIL R1: actual=%b expected=0 after one cycle", out_valid); end
        @(negedge clk);
    endtask

    // Dither one pixel and compare every channel with the register model.
    task automatic dith_px(input string req, input logic [11:0] r, input logic [11:0] g,
                           input logic [11:0] b, input logic sof);
        logic [11:0] v [3];
        logic [11:0] raw [3];
        logic [11:0] n, e;
        logic [27:0] use_s [3];
        int drop;
        v[0] = r; v[1] = g; v[2] = b;
        drop = (dith_depth == 2'd0) ? 6 : (dith_depth == 2'd1) ? 4 : (dith_depth == 2'd2) ? 2 : 0;
        for (int c = 0; c < 3; c++) use_s[c] = (sof && frame_rand) ? seed_m(dith_mode) : m[c];
        send(r, g, b, sof);
        for (int c = 0; c < 3; c++) begin
            raw[c] = chan_rand ? use_s[c][11:0] : use_s[0][11:0];
            n = hp_rand ? raw[c] - mprev[c] : raw[c];
            e = red_m(v[c], n & ~(12'hFFF << drop), drop);
            check(req, (c == 0) ? out_r : (c == 1) ? out_g : out_b, e);
        end
        for (int c = 0; c < 3; c++) begin mprev[c] = raw[c]; m[c] = step_m(use_s[c], tap_m(c)); end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        in_r = '0; in_g = '0; in_b = '0; in_is422 = 0; trunc_en = 0; trunc_mode = 0;
        trunc_depth = 0; dith_en = 0; dith_depth = 0; dith_mode = 0;
        frame_rand = 0; chan_rand = 0; hp_rand = 0;
        do_reset();
        // Reset state
        check("R1 reset valid", {11'd0, out_valid}, 12'd0);
        check("R1 reset data", out_r, 12'd0);

        // Table walk: pass-through, truncation, rounding, 4:2:2 (R2 R3 R4 R5)
        for (int i = 0; i < NV; i++) begin
            in_is422 = VEC[i][28]; trunc_en = VEC[i][27];
            trunc_depth = VEC[i][26:25]; trunc_mode = VEC[i][24];
            send(VEC[i][23:12], VEC[i][23:12], VEC[i][23:12], 1'b0);
            check($sformatf("R2/R3/R4/R5 vec%0d r", i), out_r, VEC[i][11:0]);
            check($sformatf("R2/R3/R4/R5 vec%0d g", i), out_g, VEC[i][11:0]);
            check($sformatf("R2/R3/R4/R5 vec%0d b", i), out_b, VEC[i][11:0]);
        end
        in_is422 = 0;

        // R1: markers delayed with the data
        send(12'h123, 12'h456, 12'h789, 1'b1);
        check("R1 out_valid", {11'd0, out_valid}, 12'd1);
        check("R1 out_sof", {11'd0, out_sof}, 12'd1);

        // R6 R7 R9: dither over truncation, shared register, seed A
        trunc_en = 1; trunc_depth = 2'd0; dith_en = 1; dith_depth = 2'd1; dith_mode = 2'd0;
        do_reset();
        for (int k = 0; k < 5; k++) dith_px("R6 R7 R9 shared", 12'h3A5 + 12'(k * 37), 12'h7F3, 12'h101, 1'b0);
        // R6: saturation at full scale
        dith_px("R6 sat", 12'hFFF, 12'hFFC, 12'h000, 1'b0);
        check("R6 sat r", out_r, 12'hFF0);

        // R8 R9: per-channel taps, seed C, 6-bit depth
        chan_rand = 1; dith_mode = 2'd2; dith_depth = 2'd0;
        do_reset();
        for (int k = 0; k < 6; k++) dith_px("R8 R9 per-channel", 12'h800, 12'h455, 12'hAAA - 12'(k), 1'b0);

        // R10: sof ignored when frame_rand=0, reseed when 1
        dith_mode = 2'd1; dith_depth = 2'd2;
        do_reset();
        dith_px("R10 free", 12'h100, 12'h200, 12'h300, 1'b0);
        dith_px("R10 sof ignored", 12'h100, 12'h200, 12'h300, 1'b1);
        frame_rand = 1;
        dith_px("R10 run", 12'h101, 12'h202, 12'h303, 1'b0);
        dith_px("R10 reseed", 12'h101, 12'h202, 12'h303, 1'b1);
        dith_px("R10 after", 12'h101, 12'h202, 12'h303, 1'b0);
        frame_rand = 0;

        // R11: high-pass noise, seed 3
        hp_rand = 1; dith_mode = 2'd3; dith_depth = 2'd0;
        do_reset();
        for (int k = 0; k < 5; k++) dith_px("R11 high-pass", 12'h5C0, 12'h040, 12'hF80, 1'b0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule